// File: doc/BRIEF.md
# Bytecode-State Entry Control Unit

This unit sits beside the branch logic of a processor core and settles, one request at a time, what a branch-to-bytecode instruction does. It decides between three outcomes: a plain register branch, entry into bytecode execution state, or a diversion to a configuration-invalid handler. The decision rests on two control bits held here, a main enable bit and a configuration-valid bit. It also depends on a "would enter" condition that the core supplies with each request.

The control bits and the handler base address are written and read through a small coprocessor-style register port. The valid bit is self-managing. A diversion to the handler sets it, and every exception entry clears it. As a result, a reconfiguration handler runs once after each context switch, and then bytecode entry is retried. A build parameter marks a trivial implementation, in which exceptions leave the valid bit alone. A second parameter chooses the outcome when the unit is enabled but not configured and the "would enter" condition is false.

Each accepted request produces a registered, one-cycle action. The action is a one-hot code with a target address. A separate bytecode-state flag follows the actions and exceptions.

Top module: `bcx_entry_unit`

## Requirements
- R1: With the enable bit at 0, an accepted request (`req_valid`=1) yields action BRANCH (code 3'b001) with target `req_target`, whatever the valid bit and `req_would_enter` hold.
- R2: With enable=1 and valid=1, a request yields ENTER (3'b010) with target `req_target` when `req_would_enter`=1. It yields BRANCH when `req_would_enter`=0.
- R3: With enable=1, valid=0 and `req_would_enter`=1, a request yields HANDLER (3'b100) with the current handler base as target.
- R4: A HANDLER action sets the valid bit to 1 from the next cycle. The handler set outranks a register write to the valid bit in the same cycle.
- R5: With `TRIVIAL`=0, `exc_entry` clears the valid bit from the next cycle. With `TRIVIAL`=1, `exc_entry` leaves the valid bit as it would otherwise become.
- R6: With enable=1, valid=0 and `req_would_enter`=0, a request yields HANDLER if `NOWE_HANDLER`=1 and BRANCH if it is 0.
- R7: When `exc_entry` and a HANDLER diversion fall in the same cycle with `TRIVIAL`=0, the valid bit ends at 0.
- R8: After reset, enable=0, valid=0, the handler base equals `HBASE_RST`, `act_valid`=0, `act_code`=0, `act_target`=0 and `bc_state`=0.
- R9: A register write in the same cycle as a request does not influence that request's decision. It takes effect from the next request.
- R10: The action appears exactly one cycle after the request. In any cycle that follows no request, `act_valid`=0, `act_code`=3'b000 and `act_target`=0. `act_valid` equals OR of `act_code`, and `act_code` has at most one bit set.
- R11: Register port: select 0 holds the enable bit at bit 0, select 1 holds the valid bit at bit 0, select 2 holds the full handler base, and select 3 reads 0 and ignores writes. Reads are combinational from the current state, with unused high bits 0.
- R12: `bc_state` becomes 1 the cycle after an ENTER action. It becomes 0 after a BRANCH or HANDLER action or after `exc_entry`, with the exception taking priority. Otherwise it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Branch-to-bytecode request strobe |
| req_target | input | ADDR_W | Register branch / bytecode target address |
| req_would_enter | input | 1 | Core's condition that bytecode entry would occur |
| exc_entry | input | 1 | Exception entry pulse |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register write select |
| wr_data | input | ADDR_W | Register write data |
| rd_sel | input | 2 | Register read select |
| rd_data | output | ADDR_W | Register read data |
| act_valid | output | 1 | Action present this cycle |
| act_code | output | 3 | One-hot action: BRANCH, ENTER, HANDLER |
| act_target | output | ADDR_W | Action target address |
| bc_state | output | 1 | Bytecode execution state flag |

## Verification
The bench builds two copies side by side with a 16-bit address, both driven by the same stimulus. The first has `TRIVIAL`=0 and `NOWE_HANDLER`=1. The second has `TRIVIAL`=1 and `NOWE_HANDLER`=0. Between them, both exception behaviours and both choices for the unconfigured, not-entering case are covered in a single sweep. That sweep walks every combination of enable, valid, "would enter", exception, and a colliding enable write. Expected actions, targets and register contents come from a small arithmetic model in the bench.

// File: rtl/bcx_pkg.sv
package bcx_pkg;

    typedef enum logic [2:0] {
        ACT_NONE    = 3'b000,
        ACT_BRANCH  = 3'b001,
        ACT_ENTER   = 3'b010,
        ACT_HANDLER = 3'b100
    } act_e;

    localparam logic [1:0] SEL_EN    = 2'd0;
    localparam logic [1:0] SEL_VLD   = 2'd1;
    localparam logic [1:0] SEL_HBASE = 2'd2;

endpackage

// File: rtl/bcx_decide.sv
module bcx_decide
    import bcx_pkg::*;
#(
    parameter bit NOWE_HANDLER = 1'b1
) (
    input  logic req_valid,
    input  logic would_enter,
    input  logic en,
    input  logic vld,
    output act_e act
);

    always_comb begin
        act = ACT_NONE;
        if (req_valid) begin
            if (!en) begin
                act = ACT_BRANCH;
            end else if (vld) begin
                act = would_enter ? ACT_ENTER : ACT_BRANCH;
            end else if (would_enter) begin
                act = ACT_HANDLER;
            end else begin
                act = NOWE_HANDLER ? ACT_HANDLER : ACT_BRANCH;
            end
        end
    end

endmodule

// File: rtl/bcx_ctrl_regs.sv
module bcx_ctrl_regs
    import bcx_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter bit          TRIVIAL   = 1'b0,
    parameter logic [ADDR_W-1:0] HBASE_RST = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_entry,
    input  logic              divert,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [1:0]        rd_sel,
    output logic              en,
    output logic              vld,
    output logic [ADDR_W-1:0] hbase,
    output logic [ADDR_W-1:0] rd_data
);

    typedef struct packed {
        logic              en;
        logic              vld;
        logic [ADDR_W-1:0] hbase;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  exc_clr;

    generate
        if (TRIVIAL) begin : g_trivial
            assign exc_clr = 1'b0;
        end else begin : g_full
            assign exc_clr = exc_entry;
        end
    endgenerate

    always_comb begin
        regs_d = regs_q;
        if (wr_en && wr_sel == SEL_EN)    regs_d.en    = wr_data[0];
        if (wr_en && wr_sel == SEL_VLD)   regs_d.vld   = wr_data[0];
        if (wr_en && wr_sel == SEL_HBASE) regs_d.hbase = wr_data;
        if (divert)                       regs_d.vld   = 1'b1;
        if (exc_clr)                      regs_d.vld   = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q.en    <= 1'b0;
            regs_q.vld   <= 1'b0;
            regs_q.hbase <= HBASE_RST;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign en    = regs_q.en;
    assign vld   = regs_q.vld;
    assign hbase = regs_q.hbase;

    always_comb begin
        rd_data = '0;
        case (rd_sel)
            SEL_EN:    rd_data[0] = regs_q.en;
            SEL_VLD:   rd_data[0] = regs_q.vld;
            SEL_HBASE: rd_data    = regs_q.hbase;
            default:   rd_data    = '0;
        endcase
    end

    // R4: a diversion leaves the valid bit set unless an exception clears it
    p_divert_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (divert && !exc_clr) |=> vld);

    generate
        if (!TRIVIAL) begin : g_chk_full
            // R5, R7: exception clears valid bit, outranking diversion
            p_exc_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
                exc_entry |=> !vld);
        end else begin : g_chk_triv
            // R5: trivial build, exception alone does not touch valid bit
            p_exc_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (exc_entry && !divert && !(wr_en && wr_sel == SEL_VLD)) |=> $stable(vld));
        end
    endgenerate

endmodule

// File: rtl/bcx_entry_unit.sv
module bcx_entry_unit
    import bcx_pkg::*;
#(
    parameter int          ADDR_W       = 32,
    parameter bit          TRIVIAL      = 1'b0,
    parameter bit          NOWE_HANDLER = 1'b1,
    parameter logic [ADDR_W-1:0] HBASE_RST = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_target,
    input  logic              req_would_enter,
    input  logic              exc_entry,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [1:0]        rd_sel,
    output logic [ADDR_W-1:0] rd_data,
    output logic              act_valid,
    output logic [2:0]        act_code,
    output logic [ADDR_W-1:0] act_target,
    output logic              bc_state
);

    typedef struct packed {
        act_e              act;
        logic [ADDR_W-1:0] target;
        logic              bc;
    } out_t;

    out_t              out_d, out_q;
    logic              en, vld;
    logic [ADDR_W-1:0] hbase;
    act_e              act;

    bcx_ctrl_regs #(
        .ADDR_W    (ADDR_W),
        .TRIVIAL   (TRIVIAL),
        .HBASE_RST (HBASE_RST)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .exc_entry (exc_entry),
        .divert    (act == ACT_HANDLER),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .rd_sel    (rd_sel),
        .en        (en),
        .vld       (vld),
        .hbase     (hbase),
        .rd_data   (rd_data)
    );

    bcx_decide #(
        .NOWE_HANDLER (NOWE_HANDLER)
    ) u_decide (
        .req_valid   (req_valid),
        .would_enter (req_would_enter),
        .en          (en),
        .vld         (vld),
        .act         (act)
    );

    always_comb begin
        out_d        = out_q;
        out_d.act    = act;
        out_d.target = '0;
        case (act)
            ACT_BRANCH, ACT_ENTER: out_d.target = req_target;
            ACT_HANDLER:           out_d.target = hbase;
            default:               out_d.target = '0;
        endcase
        if (act != ACT_NONE) out_d.bc = (act == ACT_ENTER);
        if (exc_entry)       out_d.bc = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q.act    <= ACT_NONE;
            out_q.target <= '0;
            out_q.bc     <= 1'b0;
        end else begin
            out_q <= out_d;
        end
    end

    assign act_code   = out_q.act;
    assign act_valid  = (out_q.act != ACT_NONE);
    assign act_target = out_q.target;
    assign bc_state   = out_q.bc;

    // R10: at most one action bit, one cycle after a request only
    p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(act_code) && (act_valid == (act_code != 3'b000)));
    p_no_req_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !act_valid);

    // R1: disabled unit always branches to the request target
    p_disabled_branch_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !en) |=> (act_code == 3'b001 && act_target == $past(req_target)));

    // R3: configuration-invalid diversion goes to the handler base
    p_handler_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && en && !vld && req_would_enter) |=>
            (act_code == 3'b100 && act_target == $past(hbase)));

    // R12: exception leaves the bytecode-state flag clear
    p_exc_state_r12: assert property (@(posedge clk) disable iff (!rst_n)
        exc_entry |=> !bc_state);

endmodule

// File: tb/sim_bcx_entry_unit.sv
module sim_bcx_entry_unit;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_target = '0;
    logic          req_would_enter = 1'b0;
    logic          exc_entry = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = '0;
    logic [AW-1:0] wr_data = '0;
    logic [1:0]    rd_sel = '0;

    logic [AW-1:0] rd_data [2];
    logic          act_valid [2];
    logic [2:0]    act_code [2];
    logic [AW-1:0] act_target [2];
    logic          bc_state [2];

    int n_chk = 0;
    int n_err = 0;

    // model configuration per instance
    bit            m_triv [2] = '{1'b0, 1'b1};
    bit            m_nowe [2] = '{1'b1, 1'b0};
    logic [AW-1:0] m_hrst [2] = '{16'h0400, 16'h0800};
    logic          m_en [2];
    logic          m_vld [2];
    logic          m_bc [2];
    logic [AW-1:0] m_hb [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    bcx_entry_unit #(.ADDR_W(AW), .TRIVIAL(1'b0), .NOWE_HANDLER(1'b1), .HBASE_RST(16'h0400)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_target(req_target),
        .req_would_enter(req_would_enter), .exc_entry(exc_entry), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data[0]),
        .act_valid(act_valid[0]), .act_code(act_code[0]), .act_target(act_target[0]),
        .bc_state(bc_state[0]));

    bcx_entry_unit #(.ADDR_W(AW), .TRIVIAL(1'b1), .NOWE_HANDLER(1'b0), .HBASE_RST(16'h0800)) u1 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_target(req_target),
        .req_would_enter(req_would_enter), .exc_entry(exc_entry), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data[1]),
        .act_valid(act_valid[1]), .act_code(act_code[1]), .act_target(act_target[1]),
        .bc_state(bc_state[1]));

    task automatic chk(string tag, int k, string what, logic [AW-1:0] act, logic [AW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s u%0d %s: actual=%h expected=%h", tag, k, what, act, exp);
        end
    endtask

    task automatic check_regs(string tag);
        for (int s = 0; s < 4; s++) begin
            rd_sel = 2'(s);
            #1;
            for (int k = 0; k < 2; k++) begin
                logic [AW-1:0] e;
                case (s)
                    0:       e = {{(AW-1){1'b0}}, m_en[k]};
                    1:       e = {{(AW-1){1'b0}}, m_vld[k]};
                    2:       e = m_hb[k];
                    default: e = '0;
                endcase
                chk(tag, k, $sformatf("rd sel%0d", s), rd_data[k], e);
            end
        end
    endtask

    // one cycle of stimulus, then a check of the registered action
    task automatic step(bit rq, bit we, logic [AW-1:0] tg, bit ex,
                        bit wr, logic [1:0] ws, logic [AW-1:0] wd, string tag);
        logic [2:0]    ea [2];
        logic [AW-1:0] et [2];
        @(negedge clk);
        req_valid = rq; req_would_enter = we; req_target = tg;
        exc_entry = ex; wr_en = wr; wr_sel = ws; wr_data = wd;
        for (int k = 0; k < 2; k++) begin
            ea[k] = 3'b000;
            if (rq) begin
                if (!m_en[k])      ea[k] = 3'b001;
                else if (m_vld[k]) ea[k] = we ? 3'b010 : 3'b001;
                else if (we)       ea[k] = 3'b100;
                else               ea[k] = m_nowe[k] ? 3'b100 : 3'b001;
            end
            et[k] = (ea[k] == 3'b100) ? m_hb[k] : (ea[k] != 3'b000 ? tg : '0);
            if (ea[k] != 3'b000) m_bc[k] = (ea[k] == 3'b010);
            if (ex) m_bc[k] = 1'b0;
            if (wr && ws == 2'd0) m_en[k] = wd[0];
            if (wr && ws == 2'd1) m_vld[k] = wd[0];
            if (wr && ws == 2'd2) m_hb[k] = wd;
            if (ea[k] == 3'b100) m_vld[k] = 1'b1;
            if (ex && !m_triv[k]) m_vld[k] = 1'b0;
        end
        @(negedge clk);
        req_valid = 1'b0; exc_entry = 1'b0; wr_en = 1'b0;
        for (int k = 0; k < 2; k++) begin
            chk(tag, k, "act_code", AW'(act_code[k]), AW'(ea[k]));
            chk(tag, k, "act_target", act_target[k], et[k]);
            chk("R10", k, "act_valid", AW'(act_valid[k]), AW'(ea[k] != 3'b000));
            chk("R12", k, "bc_state", AW'(bc_state[k]), AW'(m_bc[k]));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        for (int k = 0; k < 2; k++) begin
            m_en[k] = 1'b0; m_vld[k] = 1'b0; m_bc[k] = 1'b0; m_hb[k] = m_hrst[k];
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R8: reset state
        for (int k = 0; k < 2; k++) begin
            chk("R8", k, "act_valid", AW'(act_valid[k]), '0);
            chk("R8", k, "act_code", AW'(act_code[k]), '0);
            chk("R8", k, "act_target", act_target[k], '0);
            chk("R8", k, "bc_state", AW'(bc_state[k]), '0);
        end
        check_regs("R8");

        // R11: write select 3 ignored, handler base writable
        step(0, 0, '0, 0, 1, 2'd3, 16'hFFFF, "R11");
        check_regs("R11");
        step(0, 0, '0, 0, 1, 2'd2, 16'h1230, "R11");
        check_regs("R11");

        // near-exhaustive sweep
        for (int i = 0; i < 32; i++) begin
            bit e, v, we, ex, c;
            string t;
            logic [AW-1:0] tg;
            e = i[0]; v = i[1]; we = i[2]; ex = i[3]; c = i[4];
            tg = 16'h2000 + 16'(i * 4);
            t = c ? "R9" : ex ? "R7" : !e ? "R1" : v ? "R2" : we ? "R3" : "R6";
            if (i % 8 == 5) step(0, 0, '0, 0, 1, 2'd2, 16'h3000 + 16'(i), "R11");
            step(0, 0, '0, 0, 1, 2'd0, AW'(e), "R11");
            step(0, 0, '0, 0, 1, 2'd1, AW'(v), "R11");
            // colliding write flips enable; decision must use the old value
            step(1, we, tg, ex, c, 2'd0, AW'(!e), t);
            check_regs(ex ? "R5" : "R4");
            step(0, 0, '0, 0, 0, 2'd0, '0, "R10");
        end

        // R4: handler set outranks a same-cycle valid write of 0
        step(0, 0, '0, 0, 1, 2'd0, 16'h1, "R11");
        step(0, 0, '0, 0, 1, 2'd1, 16'h0, "R11");
        step(1, 1, 16'h4444, 0, 1, 2'd1, 16'h0, "R3");
        check_regs("R4");
        // R2 then exception-only clear (R5) and bytecode-state clear (R12)
        step(1, 1, 16'h5550, 0, 0, 2'd0, '0, "R2");
        step(0, 0, '0, 1, 0, 2'd0, '0, "R5");
        check_regs("R5");
        step(1, 1, 16'h6660, 0, 0, 2'd0, '0, "R3");
        step(1, 1, 16'h6670, 0, 0, 2'd0, '0, "R2");
        step(1, 0, 16'h6680, 0, 0, 2'd0, '0, "R2");
        step(0, 0, '0, 0, 0, 2'd0, '0, "R10");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule